// File: doc/BRIEF.md
# Divider Tick Generator

This block keeps a 14-bit free-running system counter that advances once per machine cycle; one clock edge is one machine cycle. The upper eight counter bits are presented as the readable divider value. A 2-bit rate code picks one of four counter bits as the timer source. That bit is combined with an enable and followed by a falling-edge detector. Each detected fall produces a one-cycle timer tick. A second falling-edge detector watches a higher counter bit and produces an audio-sequencer step event.

The tick depends only on the level of the chosen bit. Because of this, any action that drops that level produces a tick. Such actions are clearing the counter, moving the selection to a bit that is low, and, in one variant, switching the enable off. The parameter `COLOR_VARIANT` sets where the enable is applied. When it is 0, the enable gates the bit ahead of the edge detector. When it is 1, the enable gates the detector's output. A stop input freezes the counter.

Top module: `divtick_gen`

## Requirements
- R1: On each clock with `stop_i` low and no divider write, the counter increases by one, modulo 2^14. `div_o` shows counter bits 13..6.
- R2: While `stop_i` is high and no divider write occurs, the counter holds its value.
- R3: A clock with `div_wr_i` high clears the whole counter to zero, whatever the state of `stop_i`.
- R4: A control write latches `ctl_data_i`. Bit 2 is the enable. Bits 1:0 pick the tapped counter bit: 00 selects bit 7, 01 selects bit 1, 10 selects bit 3 and 11 selects bit 5.
- R5: When the enabled tapped bit falls, `tick_o` is high for exactly one cycle. With the counter running, one tick occurs every 2^(b+1) cycles for tap bit b.
- R6: When the timer is enabled, a control write that moves the selection from a tapped bit that is 1 to a bit that is 0 produces one tick.
- R7: With `COLOR_VARIANT`=0, clearing the enable while the tapped bit is 1 produces exactly one tick. Setting the enable while the bit is 1 produces none.
- R8: With `COLOR_VARIANT`=1, clearing or setting the enable while the tapped bit is 1 produces no tick.
- R9: While the enable has been low for the current and the previous cycle, `tick_o` stays low.
- R10: `aud_evt_o` pulses for one cycle when counter bit 10 falls. When `dbl_speed_i` is high, it pulses when bit 11 falls instead.
- R11: Clearing the counter while the tapped bit or the audio bit is 1 fires `tick_o` or `aud_evt_o` in the cycle after the write.
- R12: Reset leaves the counter at zero, the control value at 0 (disabled, selection 00), and all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| stop_i | input | 1 | Freezes the system counter |
| div_wr_i | input | 1 | Divider write strobe; clears the counter |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_data_i | input | 3 | Control value: bit 2 enable, bits 1:0 rate code |
| dbl_speed_i | input | 1 | Moves the audio tap from bit 10 to bit 11 |
| div_o | output | 8 | Counter bits 13..6 |
| tick_o | output | 1 | One-cycle timer tick |
| aud_evt_o | output | 1 | One-cycle audio-sequencer step event |

## Verification
The assertions assume that `rst_n` leaves reset away from the clock edge. They also assume that the strobes and control data are steady around each edge, so every write lands in exactly one cycle. The bench changes all inputs on the falling clock edge and holds each strobe for one full cycle. It uses `stop_i` to freeze the counter at a known value before it probes select, enable and clear interactions. That way a tick can come only from the write under test and never from the counter itself moving.

// File: rtl/divtick_pkg.sv
package divtick_pkg;

  typedef struct packed {
    logic       en;
    logic [1:0] rate;
  } tctl_t;

  // rate code -> tapped counter bit: 00->7, 01->1, 10->3, 11->5
  function automatic logic [3:0] tap_of_rate(input logic [1:0] rate);
    logic [1:0] rm1;
    rm1 = rate - 2'd1;
    return (rate == 2'b00) ? 4'd7 : {1'b0, rm1, 1'b1};
  endfunction

endpackage

// File: rtl/dt_sys_counter.sv
module dt_sys_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | ~stop_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && !clr_i) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !clr_i) |=> $stable(cnt_q));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/dt_tap_select.sv
module dt_tap_select #(
  parameter int W             = 14,
  parameter bit COLOR_VARIANT = 1'b0
) (
  input  logic [W-1:0] cnt_i,
  input  logic [1:0]   rate_i,
  input  logic         en_i,
  output logic         level_o,
  output logic         gate_o
);
  import divtick_pkg::*;

  localparam int IDX_W = $clog2(W);

  logic [IDX_W-1:0] idx;
  logic             tap_bit;

  always_comb begin
    idx     = IDX_W'(tap_of_rate(rate_i));
    tap_bit = cnt_i[idx];
  end

  generate
    if (COLOR_VARIANT) begin : g_gate_after
      // enable masks the detector output; detector sees the raw bit
      assign level_o = tap_bit;
      assign gate_o  = en_i;
    end else begin : g_gate_before
      // enable masks the bit before the detector
      assign level_o = tap_bit & en_i;
      assign gate_o  = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/dt_fall_detect.sv
module dt_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic gate_i,
  output logic pulse_o
);

  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign pulse_o = gate_i & prev_q & ~level_i;

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/divtick_gen.sv
module divtick_gen #(
  parameter int CNT_W         = 14,
  parameter int DIV_W         = 8,
  parameter int AUD_TAP       = 10,
  parameter bit COLOR_VARIANT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             div_wr_i,
  input  logic             ctl_wr_i,
  input  logic [2:0]       ctl_data_i,
  input  logic             dbl_speed_i,
  output logic [DIV_W-1:0] div_o,
  output logic             tick_o,
  output logic             aud_evt_o
);
  import divtick_pkg::*;

  localparam int IDX_W = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt;
  tctl_t            ctl_q;
  tctl_t            ctl_d;
  logic             tap_level;
  logic             tap_gate;
  logic [IDX_W-1:0] aud_idx;
  logic             aud_level;

  dt_sys_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .stop_i (stop_i),
    .clr_i  (div_wr_i),
    .cnt_o  (cnt)
  );

  always_comb ctl_d = tctl_t'(ctl_data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (ctl_wr_i) ctl_q <= ctl_d;
  end

  dt_tap_select #(.W(CNT_W), .COLOR_VARIANT(COLOR_VARIANT)) u_tap (
    .cnt_i   (cnt),
    .rate_i  (ctl_q.rate),
    .en_i    (ctl_q.en),
    .level_o (tap_level),
    .gate_o  (tap_gate)
  );

  dt_fall_detect u_tick_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (tap_level),
    .gate_i  (tap_gate),
    .pulse_o (tick_o)
  );

  always_comb begin
    aud_idx   = dbl_speed_i ? IDX_W'(AUD_TAP + 1) : IDX_W'(AUD_TAP);
    aud_level = cnt[aud_idx];
  end

  dt_fall_detect u_aud_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (aud_level),
    .gate_i  (1'b1),
    .pulse_o (aud_evt_o)
  );

  assign div_o = cnt[CNT_W-1 -: DIV_W];

  assert_idle_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !$past(ctl_q.en)) |-> !tick_o);

  assert_clear_zero_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr_i |=> (div_o == '0));

  assert_aud_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    aud_evt_o |=> !aud_evt_o);

endmodule

// File: tb/divtick_gen_tb.sv
module divtick_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_i;
  logic       div_wr_i;
  logic       ctl_wr_i;
  logic [2:0] ctl_data_i;
  logic       dbl_speed_i;
  logic [7:0] div_m, div_c;
  logic       tick_m, tick_c, aud_m, aud_c;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  divtick_gen #(.COLOR_VARIANT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .div_wr_i(div_wr_i),
    .ctl_wr_i(ctl_wr_i), .ctl_data_i(ctl_data_i), .dbl_speed_i(dbl_speed_i),
    .div_o(div_m), .tick_o(tick_m), .aud_evt_o(aud_m)
  );

  divtick_gen #(.COLOR_VARIANT(1'b1)) u_dut_color (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .div_wr_i(div_wr_i),
    .ctl_wr_i(ctl_wr_i), .ctl_data_i(ctl_data_i), .dbl_speed_i(dbl_speed_i),
    .div_o(div_c), .tick_o(tick_c), .aud_evt_o(aud_c)
  );

  typedef struct packed {
    logic [2:0] ctl;
    int         win;
    int         ticks;
    logic [7:0] div;
  } vec_t;

  // ticks over win cycles from counter=1: floor((1+win)/2^(b+1))
  localparam vec_t VEC [6] = '{
    '{3'h5,  63, 16, 8'd1},
    '{3'h6,  63,  4, 8'd1},
    '{3'h7,  63,  1, 8'd1},
    '{3'h4, 255,  1, 8'd4},
    '{3'h1,  63,  0, 8'd1},
    '{3'h5,  10,  2, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic dbl);
    @(negedge clk);
    rst_n = 1'b0; stop_i = 1'b0; div_wr_i = 1'b0; ctl_wr_i = 1'b0;
    ctl_data_i = 3'h0; dbl_speed_i = dbl;
    cyc(3);
    rst_n = 1'b1;
  endtask

  // write control and return after the edge that latches it
  task automatic wr_ctl(input logic [2:0] v);
    ctl_wr_i = 1'b1; ctl_data_i = v;
    cyc();
    ctl_wr_i = 1'b0;
  endtask

  // frozen counter: write, expect tick values, then expect quiet
  task automatic probe(input logic [2:0] v, input int exp_m, input int exp_c,
                       input string req);
    wr_ctl(v);
    check({req, " mono tick"}, tick_m, exp_m);
    check({req, " color tick"}, tick_c, exp_c);
    cyc();
    check({req, " mono quiet"}, tick_m, 0);
    check({req, " color quiet"}, tick_c, 0);
  endtask

  initial begin
    rst_n = 1'b0; stop_i = 1'b0; div_wr_i = 1'b0; ctl_wr_i = 1'b0;
    ctl_data_i = 3'h0; dbl_speed_i = 1'b0;
    cyc(2);
    // R12 reset state
    check("R12 div", div_m, 0);
    check("R12 tick", tick_m | tick_c, 0);
    check("R12 aud", aud_m | aud_c, 0);

    // table of rates: R4 R5 R9 R1
    for (int i = 0; i < 6; i++) begin
      int tm, tc;
      do_reset(1'b0);
      wr_ctl(VEC[i].ctl);
      tm = 0; tc = 0;
      for (int k = 0; k < VEC[i].win; k++) begin
        cyc();
        tm += int'(tick_m);
        tc += int'(tick_c);
      end
      check($sformatf("R5 R4 R9 vec%0d mono ticks", i), tm, VEC[i].ticks);
      check($sformatf("R5 R4 R9 vec%0d color ticks", i), tc, VEC[i].ticks);
      check($sformatf("R1 vec%0d div", i), div_m, VEC[i].div);
    end

    // stop and clear: R2 R3 R1
    do_reset(1'b0);
    cyc(200);
    check("R1 div at 200", div_m, 3);
    stop_i = 1'b1;
    cyc(100);
    check("R2 div held", div_m, 3);
    stop_i = 1'b0;
    cyc(56);
    check("R1 div at 256", div_m, 4);
    stop_i = 1'b1; div_wr_i = 1'b1;
    cyc();
    div_wr_i = 1'b0; stop_i = 1'b0;
    check("R3 cleared under stop", div_m, 0);
    cyc(64);
    check("R1 recount after clear", div_m, 1);

    // frozen at 0x3FF0 with ctl=0x4: R4 R6 R7 R8 R11
    do_reset(1'b0);
    wr_ctl(3'h4);
    cyc(16'h3FEF);
    check("R1 div at 0x3FF0", div_m, 8'hFF);
    stop_i = 1'b1;
    cyc();
    check("R2 frozen no tick", tick_m | tick_c, 0);
    probe(3'h5, 1, 1, "R4 R6 rate01");
    probe(3'h4, 0, 0, "R4 back to rate00");
    probe(3'h6, 1, 1, "R4 R6 rate10");
    probe(3'h4, 0, 0, "R4 back again");
    probe(3'h7, 0, 0, "R4 rate11 high");
    probe(3'h4, 0, 0, "R4 rate11 to 00");
    probe(3'h0, 1, 0, "R7 R8 disable high");
    probe(3'h4, 0, 0, "R7 R8 enable high");
    div_wr_i = 1'b1;
    cyc();
    div_wr_i = 1'b0;
    check("R11 mono early tick", tick_m, 1);
    check("R11 color early tick", tick_c, 1);
    check("R11 early aud", aud_m, 1);
    check("R3 div zero", div_m, 0);
    cyc();
    check("R11 tick quiet", tick_m | tick_c, 0);
    check("R11 aud quiet", aud_m, 0);
    stop_i = 1'b0;

    // audio tap: R10
    for (int d = 0; d < 2; d++) begin
      int ev;
      do_reset(d[0]);
      ev = 0;
      for (int k = 0; k < 4096; k++) begin
        cyc();
        ev += int'(aud_m);
      end
      check($sformatf("R10 aud events dbl=%0d", d), ev, (d == 0) ? 2 : 1);
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule